// File: doc/BRIEF.md
# Branch and Call-Frame Control Unit

This unit decides where a processor with 64-bit instruction slots fetches next. Each issued instruction is presented with its opcode, its two operand values, its 32-bit immediate, its signed 16-bit displacement and the current slot-addressed program counter. The unit evaluates conditional jumps and sends the program counter either to the next slot or to the jump target. It also handles subroutine calls and returns.

Calls and returns use an on-chip stack of saved frames. A call stores the four callee-preserved registers, the frame pointer and the return slot address, then moves the frame pointer. In the legacy mode the frame pointer advances by a fixed frame size. In the new mode it is copied from the stack-pointer register. A return pops the newest frame and hands its contents back for write-back. A return with no frame left marks the end of the program.

The call target is resolved outside the unit and arrives as an input. For indirect calls, the unit reports which register index holds that target. All outputs are combinational on the issued instruction. The frame stack changes at the clock edge where the instruction is issued.

Top module: `jump_frame_ctrl`

## Requirements
- R1: With `issue` high, an instruction that is not a taken jump, call or exit gives `next_pc = pc + 1`. This covers a jump whose condition is false, non-control opcodes and the reserved opcodes 0x0D, 0x9D, 0xE5, 0xED, 0xF5 and 0xFD. With `issue` low, `next_pc = pc` and no flag or write-back is raised.
- R2: A taken jump gives `next_pc = pc + 1 + sign_extend(offset)`.
- R3: Opcode bit 3 selects the second operand. When the bit is 1 the operand is `src_val`. When it is 0 the operand is `imm` sign-extended to 64 bits, for both unsigned and signed comparisons.
- R4: Jump opcodes have the low three bits equal to 5. Bits 7:4 select the condition:
  - 0 (opcode 0x05 only): always.
  - 1: equal. 5: not equal. 4: nonzero bitwise AND.
  - 2: unsigned greater than. 3: unsigned greater or equal. A: unsigned less than. B: unsigned less or equal.
  - 6: signed greater than. 7: signed greater or equal. C: signed less than. D: signed less or equal.
- R5: A call (0x85 or 0x8D) on a stack that is not full pushes r6–r10 and `pc + 1`, and sets `next_pc = call_target`. It raises `wb_en` with r6–r9 unchanged. The new r10 is r10 + `FRAME_STEP` when `new_mode` is 0, and r11 when `new_mode` is 1.
- R6: An exit (0x95) on a non-empty stack pops the newest frame. It raises `wb_en` with the saved r6–r10 and sets `next_pc` to the saved return slot. Frames come back in last-in, first-out order.
- R7: An exit on an empty stack raises `prog_done` for that cycle, keeps `next_pc = pc` and raises no write-back.
- R8: A call on a stack that already holds `DEPTH` frames raises `fault_overflow` and keeps `next_pc = pc`. Nothing is pushed and nothing is written back.
- R9: A taken jump whose target is below zero or at or above `prog_len` raises `fault_bounds` and keeps `next_pc = pc`. A call whose `call_target` is at or above `prog_len` does the same and pushes nothing.
- R10: `ind_reg_idx` equals `imm[3:0]` when `new_mode` is 0 and `src_idx` when `new_mode` is 1.
- R11: After reset the frame stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Instruction opcode |
| dst_val | input | 64 | Destination-register value |
| src_val | input | 64 | Source-register value |
| src_idx | input | 4 | Source-register field of the instruction |
| imm | input | 32 | Immediate field |
| offset | input | 16 | Signed jump displacement in slots |
| pc | input | PC_W | Current slot address |
| prog_len | input | PC_W | Number of slots in the program |
| call_target | input | PC_W | Resolved call destination |
| new_mode | input | 1 | 0 legacy, 1 new calling convention |
| r6_in | input | 64 | Current r6 |
| r7_in | input | 64 | Current r7 |
| r8_in | input | 64 | Current r8 |
| r9_in | input | 64 | Current r9 |
| r10_in | input | 64 | Current frame pointer |
| r11_in | input | 64 | Current stack pointer |
| next_pc | output | PC_W | Slot to fetch next |
| ind_reg_idx | output | 4 | Register holding an indirect call target |
| wb_en | output | 1 | Write r6–r10 from the wb ports |
| wb_r6 | output | 64 | r6 write-back value |
| wb_r7 | output | 64 | r7 write-back value |
| wb_r8 | output | 64 | r8 write-back value |
| wb_r9 | output | 64 | r9 write-back value |
| wb_r10 | output | 64 | r10 write-back value |
| prog_done | output | 1 | Clean end of program |
| fault_bounds | output | 1 | Control-transfer target outside the program |
| fault_overflow | output | 1 | Call with the frame stack full |

## Verification
The assertions assume that `prog_len` is nonzero and at least `pc + 1`, so the sequential slot is always legal. They also assume that inputs are stable around the clock edge at which they are taken. The stimulus keeps `pc` below a fixed `prog_len` of 1000 and changes inputs only on the falling edge. Displacements and call targets are drawn wide enough that out-of-range targets, a full stack and an empty stack all occur. Operand values are often forced equal or near the sign boundary, so that equality and signedness decisions are actually tested.

// File: rtl/jfc_pkg.sv
package jfc_pkg;
  localparam int XLEN = 64;

  typedef struct packed {
    logic [XLEN-1:0] r6;
    logic [XLEN-1:0] r7;
    logic [XLEN-1:0] r8;
    logic [XLEN-1:0] r9;
    logic [XLEN-1:0] r10;
  } saved_regs_t;

  typedef enum logic [3:0] {
    C_ALWAYS = 4'h0, C_EQ  = 4'h1, C_UGT = 4'h2, C_UGE = 4'h3,
    C_SET    = 4'h4, C_NE  = 4'h5, C_SGT = 4'h6, C_SGE = 4'h7,
    C_CALL   = 4'h8, C_EXIT = 4'h9, C_ULT = 4'hA, C_ULE = 4'hB,
    C_SLT    = 4'hC, C_SLE = 4'hD, C_RSV_E = 4'hE, C_RSV_F = 4'hF
  } cond_e;
endpackage

// File: rtl/jfc_cond.sv
module jfc_cond
  import jfc_pkg::*;
(
  input  logic [7:0]      opcode,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [31:0]     imm,
  output logic            is_jump,
  output logic            take
);
  logic [XLEN-1:0] rhs;
  logic            eq, ult, slt;
  cond_e           sel;

  assign sel = cond_e'(opcode[7:4]);
  // bit 3 picks register operand; the immediate is always sign-extended
  assign rhs = opcode[3] ? src_val : {{(XLEN-32){imm[31]}}, imm};
  assign eq  = (dst_val == rhs);
  assign ult = (dst_val < rhs);
  assign slt = ($signed(dst_val) < $signed(rhs));

  always_comb begin
    is_jump = (opcode[2:0] == 3'd5);
    take    = 1'b0;
    unique case (sel)
      C_ALWAYS: begin is_jump = is_jump & ~opcode[3]; take = 1'b1; end
      C_EQ:     take = eq;
      C_NE:     take = ~eq;
      C_SET:    take = |(dst_val & rhs);
      C_UGT:    take = ~ult & ~eq;
      C_UGE:    take = ~ult;
      C_ULT:    take = ult;
      C_ULE:    take = ult | eq;
      C_SGT:    take = ~slt & ~eq;
      C_SGE:    take = ~slt;
      C_SLT:    take = slt;
      C_SLE:    take = slt | eq;
      default:  is_jump = 1'b0;
    endcase
  end
endmodule

// File: rtl/jfc_frame_stack.sv
module jfc_frame_stack #(
  parameter int DEPTH = 64,
  parameter int W     = 352
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data,
  output logic         empty,
  output logic         full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  mem_q [DEPTH];
  logic [IW-1:0] wr_idx, rd_idx;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign wr_idx = IW'(cnt_q);
  assign rd_idx = IW'(cnt_q - CW'(1));
  assign top_data = mem_q[rd_idx];

  always_comb begin
    cnt_d = cnt_q;
    if (push && !full)      cnt_d = cnt_q + CW'(1);
    else if (pop && !empty) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem_q[wr_idx] <= push_data;
  end

  p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
  p_push_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> cnt_q == $past(cnt_q) + CW'(1));
  p_pop_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/jump_frame_ctrl.sv
module jump_frame_ctrl
  import jfc_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter int          DEPTH      = 64,
  parameter logic [63:0] FRAME_STEP = 64'h1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [7:0]      opcode,
  input  logic [63:0]     dst_val,
  input  logic [63:0]     src_val,
  input  logic [3:0]      src_idx,
  input  logic [31:0]     imm,
  input  logic [15:0]     offset,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] prog_len,
  input  logic [PC_W-1:0] call_target,
  input  logic            new_mode,
  input  logic [63:0]     r6_in,
  input  logic [63:0]     r7_in,
  input  logic [63:0]     r8_in,
  input  logic [63:0]     r9_in,
  input  logic [63:0]     r10_in,
  input  logic [63:0]     r11_in,
  output logic [PC_W-1:0] next_pc,
  output logic [3:0]      ind_reg_idx,
  output logic            wb_en,
  output logic [63:0]     wb_r6,
  output logic [63:0]     wb_r7,
  output logic [63:0]     wb_r8,
  output logic [63:0]     wb_r9,
  output logic [63:0]     wb_r10,
  output logic            prog_done,
  output logic            fault_bounds,
  output logic            fault_overflow
);
  localparam int RW = $bits(saved_regs_t);
  localparam int FW = RW + PC_W;
  localparam int TW = PC_W + 2;

  logic            is_jump, take, is_call, is_exit;
  logic            push, pop, stk_empty, stk_full;
  logic [FW-1:0]   push_data, top_data;
  saved_regs_t     cur_regs, top_regs;
  logic [PC_W-1:0] top_ret, seq_pc;
  logic [TW-1:0]   tgt;
  logic            tgt_bad, call_bad;

  jfc_cond u_cond (
    .opcode (opcode), .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .is_jump(is_jump), .take(take)
  );

  assign is_call = (opcode == 8'h85) || (opcode == 8'h8D);
  assign is_exit = (opcode == 8'h95);
  assign seq_pc  = pc + PC_W'(1);
  assign tgt     = {2'b00, pc} + TW'(1) + {{(TW-16){offset[15]}}, offset};
  assign tgt_bad = tgt[TW-1] || (tgt[TW-2:0] >= {1'b0, prog_len});
  assign call_bad = (call_target >= prog_len);
  assign ind_reg_idx = new_mode ? src_idx : imm[3:0];

  assign cur_regs  = '{r6: r6_in, r7: r7_in, r8: r8_in, r9: r9_in, r10: r10_in};
  assign push_data = {cur_regs, seq_pc};
  assign {top_regs, top_ret} = top_data;

  jfc_frame_stack #(.DEPTH(DEPTH), .W(FW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_data(push_data), .top_data(top_data),
    .empty(stk_empty), .full(stk_full)
  );

  always_comb begin
    next_pc        = pc;
    wb_en          = 1'b0;
    wb_r6          = r6_in;
    wb_r7          = r7_in;
    wb_r8          = r8_in;
    wb_r9          = r9_in;
    wb_r10         = r10_in;
    prog_done      = 1'b0;
    fault_bounds   = 1'b0;
    fault_overflow = 1'b0;
    push           = 1'b0;
    pop            = 1'b0;
    if (issue) begin
      next_pc = seq_pc;
      if (is_jump && take) begin
        if (tgt_bad) begin
          fault_bounds = 1'b1;
          next_pc      = pc;
        end else begin
          next_pc = tgt[PC_W-1:0];
        end
      end else if (is_call) begin
        if (stk_full) begin
          fault_overflow = 1'b1;
          next_pc        = pc;
        end else if (call_bad) begin
          fault_bounds = 1'b1;
          next_pc      = pc;
        end else begin
          push    = 1'b1;
          wb_en   = 1'b1;
          next_pc = call_target;
          wb_r10  = new_mode ? r11_in : r10_in + FRAME_STEP;
        end
      end else if (is_exit) begin
        if (stk_empty) begin
          prog_done = 1'b1;
          next_pc   = pc;
        end else begin
          pop     = 1'b1;
          wb_en   = 1'b1;
          next_pc = top_ret;
          wb_r6   = top_regs.r6;
          wb_r7   = top_regs.r7;
          wb_r8   = top_regs.r8;
          wb_r9   = top_regs.r9;
          wb_r10  = top_regs.r10;
        end
      end
    end
  end

  p_fault_holds_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_bounds || fault_overflow) |-> (next_pc == pc && !wb_en));
  p_done_needs_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> (stk_empty && next_pc == pc && !wb_en));
  p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({prog_done, fault_bounds, fault_overflow, wb_en}) <= 1);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> (next_pc == pc && !wb_en && !prog_done));
  p_ovf_only_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_overflow |-> stk_full);
endmodule

// File: tb/jump_frame_ctrl_bench.sv
module jump_frame_ctrl_bench;
  localparam int PW = 32;
  localparam int DEP = 4;
  localparam logic [63:0] STEP = 64'h1000;
  localparam int PLEN = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue = 1'b0, new_mode = 1'b0;
  logic [7:0] opcode = '0;
  logic [63:0] dst_val = '0, src_val = '0;
  logic [3:0] src_idx = '0;
  logic [31:0] imm = '0;
  logic [15:0] offset = '0;
  logic [PW-1:0] pc = '0, prog_len = PW'(PLEN), call_target = '0;
  logic [63:0] r6_in = '0, r7_in = '0, r8_in = '0, r9_in = '0, r10_in = '0, r11_in = '0;
  logic [PW-1:0] next_pc;
  logic [3:0] ind_reg_idx;
  logic wb_en, prog_done, fault_bounds, fault_overflow;
  logic [63:0] wb_r6, wb_r7, wb_r8, wb_r9, wb_r10;

  int n_chk = 0, n_fail = 0;

  // model of the frame stack
  logic [63:0] m_regs [DEP][5];
  longint m_ret [DEP];
  int m_cnt = 0;

  always #2 clk = ~clk;

  jump_frame_ctrl #(.PC_W(PW), .DEPTH(DEP), .FRAME_STEP(STEP)) u_jump_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .dst_val(dst_val),
    .src_val(src_val), .src_idx(src_idx), .imm(imm), .offset(offset), .pc(pc),
    .prog_len(prog_len), .call_target(call_target), .new_mode(new_mode),
    .r6_in(r6_in), .r7_in(r7_in), .r8_in(r8_in), .r9_in(r9_in), .r10_in(r10_in),
    .r11_in(r11_in), .next_pc(next_pc), .ind_reg_idx(ind_reg_idx), .wb_en(wb_en),
    .wb_r6(wb_r6), .wb_r7(wb_r7), .wb_r8(wb_r8), .wb_r9(wb_r9), .wb_r10(wb_r10),
    .prog_done(prog_done), .fault_bounds(fault_bounds), .fault_overflow(fault_overflow)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3/R4 reference: condition per high nibble, operands per bit 3
  function automatic bit cond_ref(input logic [7:0] op, input logic [63:0] a,
                                  input logic [63:0] s, input logic [31:0] i);
    logic [63:0] b;
    longint sa, sb;
    b = op[3] ? s : 64'(signed'(i));
    sa = longint'(a); sb = longint'(b);
    case (op[7:4])
      4'h0: return 1'b1;
      4'h1: return a == b;
      4'h5: return a != b;
      4'h4: return (a & b) != 0;
      4'h2: return a > b;
      4'h3: return a >= b;
      4'hA: return a < b;
      4'hB: return a <= b;
      4'h6: return sa > sb;
      4'h7: return sa >= sb;
      4'hC: return sa < sb;
      4'hD: return sa <= sb;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit is_jump_ref(input logic [7:0] op);
    if (op[2:0] != 3'd5) return 1'b0;
    if (op == 8'h0D) return 1'b0;
    return !(op[7:4] inside {4'h8, 4'h9, 4'hE, 4'hF});
  endfunction

  // one issued instruction: inputs at negedge, outputs sampled 1 ns later
  task automatic do_op(input logic [7:0] op);
    longint e_pc, t;
    bit e_wb, e_done, e_oob, e_ovf, e_push, e_pop;
    logic [63:0] e_r [5];
    string tag;
    issue = 1'b1; opcode = op;
    #1;
    e_pc = longint'(pc) + 1; e_wb = 0; e_done = 0; e_oob = 0; e_ovf = 0;
    e_push = 0; e_pop = 0; tag = "R1";
    e_r[0] = r6_in; e_r[1] = r7_in; e_r[2] = r8_in; e_r[3] = r9_in; e_r[4] = r10_in;
    if (is_jump_ref(op)) begin
      tag = "R3/R4";
      if (cond_ref(op, dst_val, src_val, imm)) begin
        t = longint'(pc) + 1 + longint'($signed(offset));
        if (t < 0 || t >= longint'(prog_len)) begin e_oob = 1; e_pc = pc; tag = "R9"; end
        else begin e_pc = t; tag = "R2"; end
      end
    end else if (op == 8'h85 || op == 8'h8D) begin
      if (m_cnt == DEP) begin e_ovf = 1; e_pc = pc; tag = "R8"; end
      else if (call_target >= prog_len) begin e_oob = 1; e_pc = pc; tag = "R9"; end
      else begin
        e_push = 1; e_wb = 1; e_pc = call_target; tag = "R5";
        e_r[4] = new_mode ? r11_in : r10_in + STEP;
      end
    end else if (op == 8'h95) begin
      if (m_cnt == 0) begin e_done = 1; e_pc = pc; tag = "R7"; end
      else begin
        e_pop = 1; e_wb = 1; e_pc = m_ret[m_cnt-1]; tag = "R6";
        for (int k = 0; k < 5; k++) e_r[k] = m_regs[m_cnt-1][k];
      end
    end
    check(next_pc == PW'(e_pc), {tag, " next_pc"}, 64'(next_pc), 64'(e_pc));
    check({wb_en, prog_done, fault_bounds, fault_overflow} == {e_wb, e_done, e_oob, e_ovf},
          {tag, " flags"}, 64'({wb_en, prog_done, fault_bounds, fault_overflow}),
          64'({e_wb, e_done, e_oob, e_ovf}));
    if (e_wb)
      check({wb_r6, wb_r7, wb_r8, wb_r9, wb_r10} == {e_r[0], e_r[1], e_r[2], e_r[3], e_r[4]},
            {tag, " write-back r6-r10"}, wb_r10, e_r[4]);
    check(ind_reg_idx == (new_mode ? src_idx : imm[3:0]), "R10 ind_reg_idx",
          64'(ind_reg_idx), 64'(new_mode ? src_idx : imm[3:0]));
    if (e_push) begin
      m_regs[m_cnt][0] = r6_in; m_regs[m_cnt][1] = r7_in; m_regs[m_cnt][2] = r8_in;
      m_regs[m_cnt][3] = r9_in; m_regs[m_cnt][4] = r10_in;
      m_ret[m_cnt] = longint'(pc) + 1; m_cnt++;
    end
    if (e_pop) m_cnt--;
    @(negedge clk);
  endtask

  task automatic rand_regs();
    r6_in = {$urandom, $urandom}; r7_in = {$urandom, $urandom};
    r8_in = {$urandom, $urandom}; r9_in = {$urandom, $urandom};
    r10_in = {$urandom, $urandom}; r11_in = {$urandom, $urandom};
    src_idx = 4'($urandom); new_mode = 1'($urandom);
    pc = PW'($urandom_range(0, PLEN - 1));
  endtask

  localparam logic [7:0] JOPS [12] = '{8'h05, 8'h15, 8'h25, 8'h35, 8'h45, 8'h55,
                                       8'h65, 8'h75, 8'hA5, 8'hB5, 8'hC5, 8'hD5};

  initial begin
    #(4 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 / R1: idle after reset holds pc, no flags
    pc = 32'd77; #1;
    check(next_pc == 32'd77 && !wb_en && !prog_done && !fault_bounds && !fault_overflow,
          "R1 idle after reset", 64'(next_pc), 64'd77);
    @(negedge clk);
    // R11 / R7: stack starts empty, exit ends program
    rand_regs(); do_op(8'h95);
    // R4: 0x0D reserved is sequential, 0x9D too
    rand_regs(); do_op(8'h0D);
    rand_regs(); do_op(8'h9D);
    // R3: sign extension of immediate on unsigned compare
    rand_regs(); dst_val = 64'hFFFF_FFFF_FFFF_FFFF; imm = 32'hFFFF_FFFF; offset = 16'd3;
    pc = 32'd10; do_op(8'h15);
    // R9: negative target
    rand_regs(); pc = 32'd2; offset = 16'hFFF0; do_op(8'h05);
    // R9: target equal to prog_len
    rand_regs(); pc = 32'(PLEN - 1); offset = 16'd0; do_op(8'h05);
    // R5/R8/R6: fill stack, overflow, unwind, then done
    for (int k = 0; k < DEP + 1; k++) begin
      rand_regs(); call_target = PW'($urandom_range(0, PLEN - 1));
      do_op(k[0] ? 8'h8D : 8'h85);
    end
    for (int k = 0; k < DEP + 1; k++) begin rand_regs(); do_op(8'h95); end
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [7:0] op;
      rand_regs();
      imm = $urandom;
      case ($urandom_range(0, 3))
        0: dst_val = 64'(signed'(imm));
        1: dst_val = {$urandom, $urandom};
        2: dst_val = {32'h0, $urandom_range(0, 3)};
        default: dst_val = {1'b1, 63'($urandom)};
      endcase
      src_val = ($urandom_range(0, 2) == 0) ? dst_val : {$urandom, $urandom};
      if ($urandom_range(0, 1) == 0) imm = 32'($urandom_range(0, 3)) - 32'd1;
      offset = 16'($urandom_range(0, 2400)) - 16'd1200;
      call_target = PW'($urandom_range(0, PLEN + 40));
      sel = $urandom_range(0, 19);
      if (sel < 14) op = JOPS[$urandom_range(0, 11)] | (8'($urandom_range(0, 1)) << 3);
      else if (sel < 16) op = ($urandom_range(0, 1) == 0) ? 8'h85 : 8'h8D;
      else if (sel < 19) op = 8'h95;
      else op = 8'h07;
      do_op(op);
    end
    issue = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule